// File: doc/BRIEF.md
# Window Watchdog Timer with Deferred Serial Clear

This block supervises system software with a windowed timeout. Once armed, it counts an external 1 ms tick. Each period is divided into two equal halves. Software must restart the count during the second half. A restart that comes too early, or no restart at all before the period ends, produces a one-clock system reset pulse. A restart is requested by a control register write. That request only takes effect when the serial bus transaction closes, which is seen as the rising edge of an active-low chip-select. The chip-select is synchronised inside the block.

A power-mode input controls the timer. In run mode it counts normally. In stop mode it holds its count, and on the return to run mode it starts a fresh period. Entering sleep mode disarms the watchdog, and software must arm it again afterwards. Software can set the arm bit but cannot clear it.

Top module: `win_wdog`

## Requirements
- R1: Control bit 7 is the arm bit. A write with bit 7 = 1 sets it. A write with bit 7 = 0 leaves it unchanged. System reset clears it. It reads back on `ctl_rdata[7]`, and the whole read word is 0 after reset.
- R2: Control bits 6:5 select the period and read back on `ctl_rdata[6:5]`. Code 00 gives 80 ticks, 01 gives 40 ticks, 10 gives 20 ticks and 11 gives 10 ticks.
- R3: The first half of the period is the closed half: a count of ticks since restart below period/2. A service that takes effect there, while armed and in run mode, produces a reset pulse.
- R4: A service that takes effect in the open half, at a count of period/2 or more, restarts the count with no reset. A full new period then follows.
- R5: A service is requested by a write with bit 4 = 1. It takes effect only at the next synchronised rising edge of `cs_n`, and it is consumed there. Bit 4 always reads back as 0.
- R6: While armed and in run mode, the tick that completes the period with no service produces a reset pulse.
- R7: Mode codes: 00 run, 01 stop, 10 sleep, 11 stop. In stop mode, ticks do not advance the count and no reset occurs. On the return from stop to run, the count restarts at zero.
- R8: While the mode is sleep, the arm bit is cleared, the count is held at zero and no reset occurs.
- R9: A service request consumed while the block is disarmed is discarded. It has no effect after a later arming.
- R10: `wd_rst` is high for exactly one clock. It is never asserted while the block is disarmed.
- R11: A write that changes the period code restarts the count at zero.
- R12: If a valid open-half service and the period-completing tick take effect in the same cycle, the service wins. No reset occurs and the count restarts.
- R13: Every reset pulse also restarts the count, so a full period precedes the next timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| tick | input | 1 | One-cycle 1 ms timebase strobe |
| mode | input | 2 | Power mode: 00 run, 01/11 stop, 10 sleep |
| ctl_wr | input | 1 | Decoded control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| cs_n | input | 1 | Serial bus chip-select, active low, asynchronous |
| ctl_rdata | output | 8 | Control register read value |
| wd_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The two functions that can meet in one cycle are the deferred service and the timeout. The service is released by the synchronised chip-select edge, and the timeout is driven by the tick that completes the period. The bench arms the shortest period and sends nine ticks. It then raises `cs_n` and times the tenth tick to land exactly on the cycle in which the synchronised edge is consumed. It judges the result by the absence of a reset pulse at that point, followed by a pulse on exactly the tenth tick after the restart. A second collision is also exercised: a period-code write lands while the count is partway through a period.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
   typedef enum logic [1:0] {
      MODE_RUN   = 2'b00,
      MODE_STOP  = 2'b01,
      MODE_SLEEP = 2'b10,
      MODE_HALT  = 2'b11
   } wd_mode_e;

   localparam int PER_CODES = 4;

   function automatic logic is_run(input logic [1:0] m);
      return m == MODE_RUN;
   endfunction

   function automatic logic is_sleep(input logic [1:0] m);
      return m == MODE_SLEEP;
   endfunction

   function automatic logic is_stop(input logic [1:0] m);
      return (m == MODE_STOP) || (m == MODE_HALT);
   endfunction
endpackage

// File: rtl/wwdt_cs_edge.sv
module wwdt_cs_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   output logic rise_o
);
   logic cs_s;
   logic cs_prev_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign cs_s = cs_n;
      end else begin : g_sync
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2+(STAGES==1):0], cs_n} & {STAGES{1'b1}};
         end
         assign cs_s = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_prev_q <= 1'b1;
      else        cs_prev_q <= cs_s;
   end

   assign rise_o = cs_s & ~cs_prev_q;
endmodule

// File: rtl/wwdt_ctl.sv
module wwdt_ctl #(
   parameter int DW      = 8,
   parameter int EN_BIT  = 7,
   parameter int PER_LSB = 5,
   parameter int SVC_BIT = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  logic          sleep,
   input  logic          cs_rise,
   output logic          en_o,
   output logic [1:0]    per_o,
   output logic          per_chg_o,
   output logic          pend_o,
   output logic [DW-1:0] rdata_o
);
   generate
      if (EN_BIT >= DW || PER_LSB + 1 >= DW || SVC_BIT >= DW) begin : g_bad_pos
         $error("wwdt_ctl: field outside data width");
      end
      if (EN_BIT == SVC_BIT || EN_BIT == PER_LSB || EN_BIT == PER_LSB + 1 ||
          SVC_BIT == PER_LSB || SVC_BIT == PER_LSB + 1) begin : g_overlap
         $error("wwdt_ctl: fields overlap");
      end
   endgenerate

   logic       en_q;
   logic [1:0] per_q;
   logic       pend_q;
   logic [1:0] per_wr;

   assign per_wr = wdata[PER_LSB +: 2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         per_q  <= 2'b00;
         pend_q <= 1'b0;
      end else begin
         if (sleep)                     en_q <= 1'b0;
         else if (wr && wdata[EN_BIT])  en_q <= 1'b1;
         if (wr) per_q <= per_wr;
         pend_q <= (pend_q & ~cs_rise) | (wr & wdata[SVC_BIT]);
      end
   end

   always_comb begin
      rdata_o                = '0;
      rdata_o[EN_BIT]        = en_q;
      rdata_o[PER_LSB +: 2]  = per_q;
   end

   assign en_o      = en_q;
   assign per_o     = per_q;
   assign pend_o    = pend_q;
   assign per_chg_o = wr && (per_wr != per_q);
endmodule

// File: rtl/wwdt_timer.sv
module wwdt_timer #(
   parameter int BASE  = 10,
   parameter int CNT_W = $clog2(BASE * 8 + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] per,
   input  logic       tick,
   input  logic       run,
   input  logic       hold_zero,
   input  logic       restart,
   output logic       terminal_o,
   output logic       open_o
);
   generate
      if (BASE < 2 || (BASE % 2) != 0) begin : g_bad_base
         $error("wwdt_timer: BASE must be even and at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term;
   logic [CNT_W-1:0] half;

   always_comb begin
      term = CNT_W'(BASE) << (2'd3 - per);
      half = term >> 1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (hold_zero)   cnt_q <= '0;
      else if (restart)     cnt_q <= '0;
      else if (run && tick) cnt_q <= cnt_q + 1'b1;
   end

   assign terminal_o = (cnt_q == term - 1'b1);
   assign open_o     = (cnt_q >= half);
endmodule

// File: rtl/win_wdog.sv
module win_wdog #(
   parameter int DW        = 8,
   parameter int EN_BIT    = 7,
   parameter int PER_LSB   = 5,
   parameter int SVC_BIT   = 4,
   parameter int BASE      = 10,
   parameter int CS_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [1:0]    mode,
   input  logic          ctl_wr,
   input  logic [DW-1:0] ctl_wdata,
   input  logic          cs_n,
   output logic [DW-1:0] ctl_rdata,
   output logic          wd_rst
);
   import wwdt_pkg::*;

   localparam int CNT_W = $clog2(BASE * 8 + 1);

   logic       cs_rise, en, per_chg, pend, terminal, open_win;
   logic [1:0] per;
   logic       run, sleep, was_stop_q, wake;
   logic       svc_take, svc_good, svc_bad, tmo, fire, restart;
   logic       wd_rst_q;

   assign run   = is_run(mode);
   assign sleep = is_sleep(mode);

   wwdt_cs_edge #(.STAGES(CS_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rise_o(cs_rise)
   );

   wwdt_ctl #(.DW(DW), .EN_BIT(EN_BIT), .PER_LSB(PER_LSB), .SVC_BIT(SVC_BIT)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata), .sleep(sleep),
      .cs_rise(cs_rise), .en_o(en), .per_o(per), .per_chg_o(per_chg),
      .pend_o(pend), .rdata_o(ctl_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         was_stop_q <= 1'b0;
         wd_rst_q   <= 1'b0;
      end else begin
         was_stop_q <= is_stop(mode);
         wd_rst_q   <= fire;
      end
   end

   assign wake     = was_stop_q & run;
   assign svc_take = cs_rise & pend & en & run;
   assign svc_good = svc_take & open_win;
   assign svc_bad  = svc_take & ~open_win;
   assign tmo      = en & run & tick & terminal & ~svc_good;
   assign fire     = tmo | svc_bad;
   assign restart  = fire | svc_good | wake | per_chg;

   wwdt_timer #(.BASE(BASE), .CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .per(per), .tick(tick), .run(run),
      .hold_zero(~en | sleep), .restart(restart),
      .terminal_o(terminal), .open_o(open_win)
   );

   assign wd_rst = wd_rst_q;
endmodule

// File: rtl/wwdt_chk.sv
module wwdt_chk #(
   parameter int DW      = 8,
   parameter int EN_BIT  = 7,
   parameter int SVC_BIT = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    mode,
   input logic [DW-1:0] ctl_rdata,
   input logic          wd_rst
);
   import wwdt_pkg::*;

   a_r1_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_rdata[EN_BIT] && mode != MODE_SLEEP) |=> ctl_rdata[EN_BIT]);

   a_r8_sleep_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_SLEEP) |=> !ctl_rdata[EN_BIT]);

   a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      wd_rst |=> !wd_rst);

   a_r10_quiet_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rdata[EN_BIT] |=> !wd_rst);

   a_r7_quiet_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_STOP || mode == MODE_HALT) |=> !wd_rst);

   a_r5_svc_reads0: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rdata[SVC_BIT]);
endmodule

bind win_wdog wwdt_chk #(.DW(DW), .EN_BIT(EN_BIT), .SVC_BIT(SVC_BIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode(mode), .ctl_rdata(ctl_rdata), .wd_rst(wd_rst)
);

// File: tb/win_wdog_tb.sv
`timescale 1ns/1ps
module win_wdog_tb;
   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = 8'h00;
   logic       cs_n = 1'b1;
   logic [7:0] ctl_rdata;
   logic       wd_rst;

   int tests = 0;
   int fails = 0;
   int pulses = 0;
   int long_pulses = 0;
   int cycles = 0;
   int base;
   logic prev_rst = 1'b0;

   always #2.5 clk = ~clk;

   win_wdog #(.CS_STAGES(SYNC)) u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .ctl_wr(ctl_wr),
      .ctl_wdata(ctl_wdata), .cs_n(cs_n), .ctl_rdata(ctl_rdata), .wd_rst(wd_rst)
   );

   always @(posedge clk) begin
      cycles++;
      if (wd_rst) begin
         pulses++;
         if (prev_rst) long_pulses++;
      end
      prev_rst = wd_rst;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: run did not finish");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; mode = 2'b00; tick = 1'b0; ctl_wr = 1'b0; cs_n = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk); ctl_wr = 1'b1; ctl_wdata = d;
      @(negedge clk); ctl_wr = 1'b0;
   endtask

   task automatic cs_pulse();
      @(negedge clk) cs_n = 1'b0;
      @(negedge clk) cs_n = 1'b1;
      repeat (SYNC + 4) @(negedge clk);
   endtask

   task automatic pulse_chk(input string req, input int exp_delta);
      check((pulses - base) == exp_delta, req, pulses - base, exp_delta);
   endtask

   // code[10:9], ticks before service[8:1], closed-half expected reset[0]
   localparam logic [10:0] VEC [8] = '{
      {2'b11, 8'd4,  1'b1}, {2'b11, 8'd5,  1'b0},
      {2'b10, 8'd9,  1'b1}, {2'b10, 8'd10, 1'b0},
      {2'b01, 8'd19, 1'b1}, {2'b01, 8'd20, 1'b0},
      {2'b00, 8'd39, 1'b1}, {2'b00, 8'd40, 1'b0}
   };

   initial begin
      do_reset();
      // R1 reset state
      check(ctl_rdata == 8'h00, "R1 reset read", ctl_rdata, 0);
      check(wd_rst == 1'b0, "R10 reset output", wd_rst, 0);

      // R3 R4 R2 window boundaries per period code
      foreach (VEC[i]) begin
         do_reset();
         wr({1'b1, VEC[i][10:9], 5'b0});
         check(ctl_rdata == {1'b1, VEC[i][10:9], 5'b0}, "R2 period readback",
               ctl_rdata, {1'b1, VEC[i][10:9], 5'b0});
         ticks(VEC[i][8:1]);
         base = pulses;
         wr({1'b1, VEC[i][10:9], 5'b10000});
         cs_pulse();
         pulse_chk(VEC[i][0] ? "R3 closed service" : "R4 open service", VEC[i][0]);
      end

      // R6 R2 timeout length, code 01 = 40 ticks
      do_reset(); base = pulses;
      wr(8'hA0); ticks(39);
      pulse_chk("R6 before period end", 0);
      ticks(1);
      pulse_chk("R6 timeout", 1);
      // R13 full period after the reset pulse
      ticks(39);
      pulse_chk("R13 after reset restart", 1);
      ticks(1);
      pulse_chk("R13 next timeout", 2);

      // R1 write of 0 to arm bit
      wr(8'h60);
      check(ctl_rdata == 8'hE0, "R1 arm bit sticky", ctl_rdata, 8'hE0);

      // R5 deferred service, then R13 after bad-service reset
      do_reset(); base = pulses;
      wr(8'hE0); ticks(2);
      wr(8'hF0);
      repeat (10) @(negedge clk);
      pulse_chk("R5 no effect before cs edge", 0);
      check(ctl_rdata[4] == 1'b0, "R5 service reads 0", ctl_rdata[4], 0);
      cs_pulse();
      pulse_chk("R5 closed service at cs edge", 1);
      ticks(9);
      pulse_chk("R13 restart after bad service", 1);
      ticks(1);
      pulse_chk("R13 timeout after bad service", 2);

      // R4 full period after good service
      do_reset(); base = pulses;
      wr(8'hE0); ticks(6);
      wr(8'hF0); cs_pulse();
      ticks(9);
      pulse_chk("R4 no reset after good service", 0);
      ticks(1);
      pulse_chk("R4 timeout one full period later", 1);

      // R7 stop freezes, wake clears (also stop code 11)
      do_reset(); base = pulses;
      wr(8'hE0); ticks(7);
      mode = 2'b01; ticks(12);
      pulse_chk("R7 no count in stop", 0);
      mode = 2'b11; ticks(5);
      mode = 2'b00; ticks(9);
      pulse_chk("R7 count cleared on wake", 0);
      ticks(1);
      pulse_chk("R7 timeout after wake", 1);

      // R8 sleep disarms
      do_reset(); base = pulses;
      wr(8'hE0); ticks(3);
      @(negedge clk) mode = 2'b10;
      @(negedge clk) mode = 2'b00;
      @(negedge clk);
      check(ctl_rdata[7] == 1'b0, "R8 arm cleared by sleep", ctl_rdata[7], 0);
      ticks(25);
      pulse_chk("R8 disarmed after sleep", 0);

      // R9 discarded service while disarmed, R10 no reset disarmed
      do_reset(); base = pulses;
      wr(8'h70); cs_pulse();
      ticks(100);
      pulse_chk("R10 silent while disarmed", 0);
      wr(8'hE0); cs_pulse();
      pulse_chk("R9 stale service discarded", 0);
      ticks(10);
      pulse_chk("R9 armed timeout", 1);

      // R11 period change restarts count
      do_reset(); base = pulses;
      wr(8'hE0); ticks(7);
      wr(8'hC0); ticks(19);
      pulse_chk("R11 restart on period change", 0);
      ticks(1);
      pulse_chk("R11 timeout new period", 1);

      // R12 open service and terminal tick in the same cycle
      do_reset(); base = pulses;
      wr(8'hE0); ticks(9);
      wr(8'hF0);
      @(negedge clk) cs_n = 1'b0;
      @(negedge clk) cs_n = 1'b1;
      repeat (SYNC) @(posedge clk);
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      repeat (4) @(negedge clk);
      pulse_chk("R12 service wins over timeout", 0);
      ticks(9);
      pulse_chk("R12 count restarted", 0);
      ticks(1);
      pulse_chk("R12 next timeout", 1);

      check(long_pulses == 0, "R10 pulse width", long_pulses, 0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule